// File: doc/BRIEF.md
# SD Card SPI-Mode Block Reader

This block brings an SD card up in SPI mode and then fetches single 512-byte blocks from it. A byte-wide SPI shifter, running SPI mode 0 with a clock divider set by parameters, drives chip select, SCLK and MOSI and samples MISO. A fixed command sequencer on top of the shifter runs the bring-up in hardware: the wake-up clocks, the reset command, the interface-condition check, the repeated operating-condition handshake and the block-length setting. The host starts this with a single-cycle `init_req` pulse and waits for `done`.

After bring-up the host pulses `rd_req` with a 32-bit block address. The engine sends the read command, waits for the start-of-data token, and streams the block out on `rd_data` with `rd_valid` and `rd_last`. The two trailing check bytes are clocked in and thrown away. Every operation ends with a one-cycle `done`. On failure, `err` is set and `err_code` names the step that failed.

Top module: `sdspi_engine`

## Requirements
- R1: Out of reset, and whenever the engine is idle, spi_cs_n is 1, spi_sclk is 0 and spi_mosi is 1. An init_req first sends WAKE_BYTES (10) bytes of 0xFF, which is 80 SCLK rising edges with MOSI high, while chip select stays high.
- R2: Every command is a 6-byte frame, each byte sent MSB first. The frame is 0x40 OR the command index, then the 32-bit argument with its most significant byte first, then a check byte. The check byte is 0x95 for CMD0 (argument 0), 0x87 for CMD8 (argument 0x000001AA) and 0xFF for all other commands.
- R3: The R1 response is the first received byte with bit 7 clear, among at most 8 bytes after a frame. If no such byte arrives, the operation ends with err=1 and an err_code for the step: 1 for CMD0, 2 for CMD8, 3 for CMD55/ACMD41, 4 for CMD16, 5 for CMD17. CMD0 also needs R1 to be exactly 0x01, otherwise the code is 1.
- R4: After the CMD8 R1, four more bytes are read. card_v2 is 1 only if the last of them is 0xAA.
- R5: CMD55 (argument 0) followed by ACMD41 (argument 0x40000000) repeats for as long as bit 0 of the ACMD41 R1 is 1. If the card is still idle after ACMD_TRIES pairs, the operation ends with err_code 3.
- R6: When the card leaves idle, CMD16 with argument 512 follows. An R1 of 0x00 ends the bring-up with err=0 and chip select high; any other R1 gives err_code 4.
- R7: SCLK runs SPI mode 0: it idles low, MOSI changes after a falling edge and MISO is sampled on a rising edge. SCLK stays high for SLOW_HALF clock cycles from init_req until CMD16 completes, and for FAST_HALF cycles after that, until the next init_req.
- R8: rd_req sends CMD17 with rd_addr as its argument. A nonzero R1 ends the read with err_code 5, raises chip select and outputs no data.
- R9: After the CMD17 R1, the engine polls bytes for as long as they read 0xFF, up to TOKEN_TRIES (1000) bytes. 0xFE starts the data. Any other value gives err_code 6; TOKEN_TRIES bytes of 0xFF give err_code 7.
- R10: After the token, exactly BLOCK_BYTES (512) bytes appear on rd_data, each with a one-cycle rd_valid, and rd_last marks only the final byte. Two more bytes are then clocked in and dropped before chip select rises and done arrives with err=0.
- R11: done is a one-cycle pulse at the end of each operation, with busy already low in that cycle. err and err_code hold until the next request, and err=1 always comes with a nonzero err_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Start card bring-up (pulse, taken when idle) |
| rd_req | input | 1 | Start a single-block read (pulse, taken when idle) |
| rd_addr | input | 32 | Block address for the read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| err | output | 1 | Last operation failed |
| err_code | output | 4 | Step that failed (0 = none) |
| card_v2 | output | 1 | Card answered the interface check with 0xAA |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | rd_data is valid this cycle |
| rd_last | output | 1 | Final byte of the block |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to the card |
| spi_miso | input | 1 | Data from the card |

## Verification
The bench pairs the engine with a behavioural card that answers each frame after a set number of 0xFF filler bytes. It targets the limits of each polling window. An R1 after 7 fillers must succeed and one after 8 must time out; a design with an off-by-one poll count would fail one of the two. For the same reason it places the data token at poll 999, which must be accepted, and at poll 1000, which must fail. A card that stays idle checks that the retry loop stops after exactly ACMD_TRIES pairs, rather than hanging or quitting early. The bench also counts every byte clocked after the read command: an engine that skipped the trailing check bytes, or passed them on as data, shows up as a wrong byte count or a 513th valid byte. SCLK high time is measured after bring-up and after a read, which catches a divider that switches too early or never switches.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

   typedef enum logic [3:0] {
      ERR_NONE    = 4'd0,
      ERR_GOIDLE  = 4'd1,
      ERR_IFCOND  = 4'd2,
      ERR_OPCOND  = 4'd3,
      ERR_BLKLEN  = 4'd4,
      ERR_RDCMD   = 4'd5,
      ERR_TOKBAD  = 4'd6,
      ERR_TOKTIME = 4'd7
   } sd_err_e;

   typedef enum logic [2:0] {
      STEP_GOIDLE, STEP_IFCOND, STEP_APPCMD, STEP_OPCOND, STEP_BLKLEN, STEP_READ
   } sd_step_e;

   typedef enum logic [2:0] {
      PH_IDLE, PH_WAKE, PH_CMD, PH_R1, PH_R7, PH_TOKEN, PH_DATA, PH_CRC
   } sd_phase_e;

   localparam logic [7:0] FILL_BYTE  = 8'hFF;
   localparam logic [7:0] START_TOK  = 8'hFE;

   function automatic logic [7:0] frame_byte(input logic [5:0] idx, input logic [31:0] arg,
                                             input logic [7:0] chk, input logic [2:0] pos);
      case (pos)
         3'd0:    return 8'h40 | {2'b00, idx};
         3'd1:    return arg[31:24];
         3'd2:    return arg[23:16];
         3'd3:    return arg[15:8];
         3'd4:    return arg[7:0];
         default: return chk;
      endcase
   endfunction

   function automatic sd_err_e step_err(input sd_step_e s);
      case (s)
         STEP_GOIDLE: return ERR_GOIDLE;
         STEP_IFCOND: return ERR_IFCOND;
         STEP_BLKLEN: return ERR_BLKLEN;
         STEP_READ:   return ERR_RDCMD;
         default:     return ERR_OPCOND;
      endcase
   endfunction

endpackage

// File: rtl/sdspi_shifter.sv
module sdspi_shifter #(
   parameter int HW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [HW-1:0] half,
   input  logic          start,
   input  logic [7:0]    tx,
   input  logic          miso,
   output logic          busy,
   output logic          done,
   output logic [7:0]    rx,
   output logic          sclk,
   output logic          mosi
);
   logic [HW-1:0] divc;
   logic [2:0]    bitn;
   logic [7:0]    txs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         sclk <= 1'b0;
         divc <= '0;
         bitn <= '0;
         txs  <= 8'hFF;
         rx   <= 8'hFF;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               txs  <= tx;
               divc <= '0;
               bitn <= '0;
            end
         end else if (divc == half - HW'(1)) begin
            divc <= '0;
            if (!sclk) begin
               sclk <= 1'b1;
               rx   <= {rx[6:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bitn == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bitn <= bitn + 3'd1;
                  txs  <= {txs[6:0], 1'b1};
               end
            end
         end else begin
            divc <= divc + HW'(1);
         end
      end
   end

   assign mosi = busy ? txs[7] : 1'b1;

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);                                                // R7
   AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);                                                // R7
   AST_DONE_ENDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(busy));                                           // R7
endmodule

// File: rtl/sdspi_seq.sv
module sdspi_seq
   import sdspi_pkg::*;
#(
   parameter int WAKE_BYTES  = 10,
   parameter int R1_TRIES    = 8,
   parameter int ACMD_TRIES  = 3000,
   parameter int TOKEN_TRIES = 1000,
   parameter int BLOCK_BYTES = 512
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init_req,
   input  logic        rd_req,
   input  logic [31:0] rd_addr,
   input  logic        sh_done,
   input  logic [7:0]  sh_rx,
   output logic        sh_start,
   output logic [7:0]  sh_tx,
   output logic        fast,
   output logic        cs_n,
   output logic        busy,
   output logic        done,
   output logic        err,
   output sd_err_e     err_code,
   output logic        card_v2,
   output logic [7:0]  rd_data,
   output logic        rd_valid,
   output logic        rd_last
);
   localparam int M1   = (TOKEN_TRIES > BLOCK_BYTES) ? TOKEN_TRIES : BLOCK_BYTES;
   localparam int M2   = (WAKE_BYTES > R1_TRIES) ? WAKE_BYTES : R1_TRIES;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXC);
   localparam int AW   = $clog2(ACMD_TRIES + 1);

   sd_phase_e      ph;
   sd_step_e       step;
   logic [CW-1:0]  cnt;
   logic [AW-1:0]  acnt;
   logic [31:0]    addr;
   logic           pend;
   logic [5:0]     c_idx;
   logic [31:0]    c_arg;
   logic [7:0]     c_chk;

   always_comb begin
      c_arg = 32'd0;
      c_chk = FILL_BYTE;
      case (step)
         STEP_IFCOND: begin c_idx = 6'd8;  c_arg = 32'h0000_01AA; c_chk = 8'h87; end
         STEP_APPCMD: c_idx = 6'd55;
         STEP_OPCOND: begin c_idx = 6'd41; c_arg = 32'h4000_0000; end
         STEP_BLKLEN: begin c_idx = 6'd16; c_arg = 32'(BLOCK_BYTES); end
         STEP_READ:   begin c_idx = 6'd17; c_arg = addr; end
         default:     begin c_idx = 6'd0;  c_chk = 8'h95; end
      endcase
   end

   assign busy = (ph != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE; step <= STEP_GOIDLE; cnt <= '0; acnt <= '0; addr <= '0;
         pend <= 1'b0; sh_start <= 1'b0; sh_tx <= FILL_BYTE; fast <= 1'b0; cs_n <= 1'b1;
         done <= 1'b0; err <= 1'b0; err_code <= ERR_NONE; card_v2 <= 1'b0;
         rd_data <= '0; rd_valid <= 1'b0; rd_last <= 1'b0;
      end else begin
         sh_start <= 1'b0;
         done     <= 1'b0;
         rd_valid <= 1'b0;
         rd_last  <= 1'b0;
         if (ph == PH_IDLE) begin
            if (init_req) begin
               ph <= PH_WAKE; cnt <= '0; acnt <= '0; fast <= 1'b0;
               err <= 1'b0; err_code <= ERR_NONE; card_v2 <= 1'b0;
            end else if (rd_req) begin
               ph <= PH_CMD; step <= STEP_READ; cnt <= '0; addr <= rd_addr;
               cs_n <= 1'b0; err <= 1'b0; err_code <= ERR_NONE;
            end
         end else if (!pend) begin
            sh_start <= 1'b1;
            sh_tx    <= (ph == PH_CMD) ? frame_byte(c_idx, c_arg, c_chk, cnt[2:0]) : FILL_BYTE;
            pend     <= 1'b1;
         end else if (sh_done) begin
            pend <= 1'b0;
            cnt  <= cnt + CW'(1);
            case (ph)
               PH_WAKE: if (cnt == CW'(WAKE_BYTES - 1)) begin
                  cs_n <= 1'b0; ph <= PH_CMD; step <= STEP_GOIDLE; cnt <= '0;
               end
               PH_CMD: if (cnt == CW'(5)) begin
                  ph <= PH_R1; cnt <= '0;
               end
               PH_R1: if (!sh_rx[7]) begin
                  cnt <= '0;
                  case (step)
                     STEP_GOIDLE: if (sh_rx == 8'h01) begin
                        step <= STEP_IFCOND; ph <= PH_CMD;
                     end else begin
                        ph <= PH_IDLE; cs_n <= 1'b1; done <= 1'b1; err <= 1'b1; err_code <= ERR_GOIDLE;
                     end
                     STEP_IFCOND: ph <= PH_R7;
                     STEP_APPCMD: begin step <= STEP_OPCOND; ph <= PH_CMD; end
                     STEP_OPCOND: if (!sh_rx[0]) begin
                        step <= STEP_BLKLEN; ph <= PH_CMD;
                     end else if (acnt == AW'(ACMD_TRIES - 1)) begin
                        ph <= PH_IDLE; cs_n <= 1'b1; done <= 1'b1; err <= 1'b1; err_code <= ERR_OPCOND;
                     end else begin
                        acnt <= acnt + AW'(1); step <= STEP_APPCMD; ph <= PH_CMD;
                     end
                     STEP_BLKLEN: begin
                        ph <= PH_IDLE; cs_n <= 1'b1; done <= 1'b1;
                        if (sh_rx == 8'h00) fast <= 1'b1;
                        else begin err <= 1'b1; err_code <= ERR_BLKLEN; end
                     end
                     default: if (sh_rx == 8'h00) begin
                        ph <= PH_TOKEN;
                     end else begin
                        ph <= PH_IDLE; cs_n <= 1'b1; done <= 1'b1; err <= 1'b1; err_code <= ERR_RDCMD;
                     end
                  endcase
               end else if (cnt == CW'(R1_TRIES - 1)) begin
                  ph <= PH_IDLE; cs_n <= 1'b1; done <= 1'b1; err <= 1'b1; err_code <= step_err(step);
               end
               PH_R7: if (cnt == CW'(3)) begin
                  card_v2 <= (sh_rx == 8'hAA); step <= STEP_APPCMD; ph <= PH_CMD; cnt <= '0;
               end
               PH_TOKEN: if (sh_rx == START_TOK) begin
                  ph <= PH_DATA; cnt <= '0;
               end else if (sh_rx != FILL_BYTE) begin
                  ph <= PH_IDLE; cs_n <= 1'b1; done <= 1'b1; err <= 1'b1; err_code <= ERR_TOKBAD;
               end else if (cnt == CW'(TOKEN_TRIES - 1)) begin
                  ph <= PH_IDLE; cs_n <= 1'b1; done <= 1'b1; err <= 1'b1; err_code <= ERR_TOKTIME;
               end
               PH_DATA: begin
                  rd_data  <= sh_rx;
                  rd_valid <= 1'b1;
                  rd_last  <= (cnt == CW'(BLOCK_BYTES - 1));
                  if (cnt == CW'(BLOCK_BYTES - 1)) begin ph <= PH_CRC; cnt <= '0; end
               end
               default: if (cnt == CW'(1)) begin
                  ph <= PH_IDLE; cs_n <= 1'b1; done <= 1'b1;
               end
            endcase
         end
      end
   end

   AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> cs_n);                                       // R1
   AST_FAST_AFTER_BLKLEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast) |-> $past(step == STEP_BLKLEN));                     // R7
   AST_VALID_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !cs_n);                                             // R10
   AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);                                           // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                 // R11
   AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (err_code != ERR_NONE));                       // R11
endmodule

// File: rtl/sdspi_engine.sv
module sdspi_engine
   import sdspi_pkg::*;
#(
   parameter int SLOW_HALF   = 157,
   parameter int FAST_HALF   = 2,
   parameter int WAKE_BYTES  = 10,
   parameter int R1_TRIES    = 8,
   parameter int ACMD_TRIES  = 3000,
   parameter int TOKEN_TRIES = 1000,
   parameter int BLOCK_BYTES = 512
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init_req,
   input  logic        rd_req,
   input  logic [31:0] rd_addr,
   output logic        busy,
   output logic        done,
   output logic        err,
   output logic [3:0]  err_code,
   output logic        card_v2,
   output logic [7:0]  rd_data,
   output logic        rd_valid,
   output logic        rd_last,
   output logic        spi_cs_n,
   output logic        spi_sclk,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   localparam int HW = $clog2(SLOW_HALF + 1);

   if (FAST_HALF < 1 || SLOW_HALF < FAST_HALF) begin : g_bad_div
      $error("divider: need 1 <= FAST_HALF <= SLOW_HALF");
   end
   if (R1_TRIES < 1 || TOKEN_TRIES < 1 || ACMD_TRIES < 1 || WAKE_BYTES < 1 || BLOCK_BYTES < 2) begin : g_bad_cnt
      $error("counts must be positive");
   end

   logic          fast, sh_start, sh_done;
   logic [7:0]    sh_tx, sh_rx;
   logic [HW-1:0] half;
   logic          sh_busy;
   sd_err_e       code;

   if (SLOW_HALF == FAST_HALF) begin : g_one_rate
      assign half = HW'(SLOW_HALF);
   end else begin : g_two_rate
      assign half = fast ? HW'(FAST_HALF) : HW'(SLOW_HALF);
   end

   sdspi_seq #(
      .WAKE_BYTES(WAKE_BYTES), .R1_TRIES(R1_TRIES), .ACMD_TRIES(ACMD_TRIES),
      .TOKEN_TRIES(TOKEN_TRIES), .BLOCK_BYTES(BLOCK_BYTES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .rd_req(rd_req), .rd_addr(rd_addr),
      .sh_done(sh_done), .sh_rx(sh_rx), .sh_start(sh_start), .sh_tx(sh_tx), .fast(fast),
      .cs_n(spi_cs_n), .busy(busy), .done(done), .err(err), .err_code(code),
      .card_v2(card_v2), .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last)
   );

   sdspi_shifter #(.HW(HW)) u_shift (
      .clk(clk), .rst_n(rst_n), .half(half), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
      .busy(sh_busy), .done(sh_done), .rx(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi)
   );

   assign err_code = code;

   AST_BYTE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> busy);                                               // R1
endmodule

// File: tb/tb_sdspi_engine.sv
`timescale 1ns/1ps
module tb_sdspi_engine;
   localparam int SLOW = 4, FAST = 1, ACMD = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0, init_req = 1'b0, rd_req = 1'b0;
   logic [31:0] rd_addr = '0;
   logic busy, done, err, card_v2, rd_valid, rd_last, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
   logic [3:0] err_code;
   logic [7:0] rd_data;

   sdspi_engine #(.SLOW_HALF(SLOW), .FAST_HALF(FAST), .ACMD_TRIES(ACMD)) dut (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .rd_req(rd_req), .rd_addr(rd_addr),
      .busy(busy), .done(done), .err(err), .err_code(err_code), .card_v2(card_v2),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last), .spi_cs_n(spi_cs_n),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

   int n_chk = 0, n_err = 0;
   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- card model ----------------
   logic        miso_r = 1'b1;
   logic [7:0]  q[$];
   int          bitn = 0;
   logic [7:0]  rxb = 8'hFF, txb = 8'hFF;
   int          fpos = 0;
   logic [7:0]  fr [6];
   int          cfg_gap, cfg_mute, cfg_busy, cfg_tokdelay;
   bit          cfg_v2;
   logic [7:0]  cfg_r1_0, cfg_r1_16, cfg_r1_17, cfg_tok;
   int          ncmd, n_acmd;
   logic [5:0]  lg_idx [64];
   logic [31:0] lg_arg [64];
   logic [7:0]  lg_chk [64];
   int          post_bytes;
   bit          counting;
   assign spi_miso = miso_r;

   function automatic logic [7:0] pat(input logic [31:0] a, input int i);
      return 8'(i) ^ a[7:0] ^ 8'h3C ^ 8'(i >> 8);
   endfunction

   task automatic push_r1(input logic [7:0] v);
      repeat (cfg_gap) q.push_back(8'hFF);
      q.push_back(v);
   endtask

   task automatic respond();
      logic [5:0]  idx = fr[0][5:0];
      logic [31:0] arg = {fr[1], fr[2], fr[3], fr[4]};
      if (ncmd < 64) begin lg_idx[ncmd] = idx; lg_arg[ncmd] = arg; lg_chk[ncmd] = fr[5]; end
      ncmd++;
      if (idx == 6'd41) n_acmd++;
      if (cfg_mute != 0) return;
      case (idx)
         6'd0:  push_r1(cfg_r1_0);
         6'd8:  if (cfg_v2) begin
                   push_r1(8'h01); q.push_back(8'h00); q.push_back(8'h00);
                   q.push_back(8'h01); q.push_back(8'hAA);
                end else push_r1(8'h05);
         6'd55: push_r1(8'h01);
         6'd41: if (cfg_busy > 0) begin cfg_busy--; push_r1(8'h01); end else push_r1(8'h00);
         6'd16: push_r1(cfg_r1_16);
         6'd17: begin
            post_bytes = 0; counting = 1;
            push_r1(cfg_r1_17);
            if (cfg_r1_17 == 8'h00) begin
               repeat (cfg_tokdelay) q.push_back(8'hFF);
               q.push_back(cfg_tok);
               if (cfg_tok == 8'hFE) begin
                  for (int i = 0; i < 512; i++) q.push_back(pat(arg, i));
                  q.push_back(8'h12); q.push_back(8'h34);
               end
            end
         end
         default: push_r1(8'h04);
      endcase
   endtask

   always @(posedge spi_sclk) if (!spi_cs_n) begin
      rxb = {rxb[6:0], spi_mosi};
      bitn++;
      if (bitn == 8) begin
         bitn = 0;
         if (counting) post_bytes++;
         if (fpos == 0 && rxb[7:6] == 2'b01) begin fr[0] = rxb; fpos = 1; end
         else if (fpos > 0) begin
            fr[fpos] = rxb; fpos++;
            if (fpos == 6) begin fpos = 0; respond(); end
         end
         txb = (q.size() > 0) ? q.pop_front() : 8'hFF;
         miso_r = txb[7];
      end
   end
   always @(negedge spi_sclk) if (!spi_cs_n && bitn != 0) miso_r = txb[7 - bitn];
   always @(posedge spi_cs_n) begin
      q.delete(); bitn = 0; fpos = 0; miso_r = 1'b1; txb = 8'hFF; counting = 0;
   end

   // ---------------- monitors ----------------
   int wake_edges, wake_bad, hi_cnt = 0, last_high = 0, nrcv, nlast, last_idx, bad_data;
   logic [31:0] exp_addr;
   always @(posedge spi_sclk) if (spi_cs_n) begin
      wake_edges++;
      if (!spi_mosi) wake_bad++;
   end
   always @(negedge clk) begin
      if (spi_sclk) hi_cnt++;
      else if (hi_cnt != 0) begin last_high = hi_cnt; hi_cnt = 0; end
      if (rd_valid) begin
         if (rd_data != pat(exp_addr, nrcv)) bad_data++;
         if (rd_last) begin nlast++; last_idx = nrcv; end
         nrcv++;
      end
   end

   task automatic cfg_default();
      cfg_gap = 1; cfg_mute = 0; cfg_busy = 0; cfg_tokdelay = 0; cfg_v2 = 1;
      cfg_r1_0 = 8'h01; cfg_r1_16 = 8'h00; cfg_r1_17 = 8'h00; cfg_tok = 8'hFE;
      ncmd = 0; n_acmd = 0; wake_edges = 0; wake_bad = 0;
      nrcv = 0; nlast = 0; last_idx = -1; bad_data = 0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 60000) begin @(negedge clk); t++; end
      @(negedge clk);
   endtask

   task automatic run_init();
      @(negedge clk) init_req = 1'b1;
      @(negedge clk) init_req = 1'b0;
      wait_done();
   endtask

   task automatic run_read(input logic [31:0] a);
      exp_addr = a;
      @(negedge clk) begin rd_req = 1'b1; rd_addr = a; end
      @(negedge clk) rd_req = 1'b0;
      wait_done();
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(spi_cs_n === 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
      chk(spi_sclk === 1'b0, "R1", "sclk after reset", spi_sclk, 0);
      chk(spi_mosi === 1'b1, "R1", "mosi after reset", spi_mosi, 1);
      chk(busy === 1'b0 && done === 1'b0, "R11", "busy/done after reset", {busy, done}, 0);
   endtask

   task automatic t_init_v2();
      int exp_idx [9] = '{0, 8, 55, 41, 55, 41, 55, 41, 16};
      bit seq_ok = 1, chk_ok = 1, arg_ok = 1;
      cfg_default(); cfg_busy = 2;
      run_init();
      chk(err == 1'b0 && err_code == 4'd0, "R6", "init err", {err, err_code}, 0);
      chk(busy == 1'b0 && spi_cs_n == 1'b1, "R6", "idle and cs high after init", {busy, spi_cs_n}, 1);
      chk(wake_edges == 80, "R1", "wake rising edges", wake_edges, 80);
      chk(wake_bad == 0, "R1", "wake edges with mosi low", wake_bad, 0);
      chk(card_v2 == 1'b1, "R4", "card_v2", card_v2, 1);
      chk(ncmd == 9, "R5", "command count", ncmd, 9);
      for (int i = 0; i < 9 && i < ncmd; i++) begin
         if (lg_idx[i] != 6'(exp_idx[i])) seq_ok = 0;
         if (lg_chk[i] != ((i == 0) ? 8'h95 : (i == 1) ? 8'h87 : 8'hFF)) chk_ok = 0;
      end
      if (lg_arg[0] != 32'h0 || lg_arg[1] != 32'h1AA || lg_arg[2] != 32'h0 ||
          lg_arg[3] != 32'h4000_0000 || lg_arg[8] != 32'd512) arg_ok = 0;
      chk(seq_ok, "R5", "command order", seq_ok, 1);
      chk(chk_ok, "R2", "check bytes 95/87/FF", chk_ok, 1);
      chk(arg_ok, "R2", "arguments incl CMD16 512", arg_ok, 1);
      chk(last_high == SLOW, "R7", "sclk high time during init", last_high, SLOW);
   endtask

   task automatic t_read_ok(input logic [31:0] a, input int tdly);
      cfg_default(); cfg_tokdelay = tdly;
      run_read(a);
      chk(err == 1'b0, "R10", "read err", err_code, 0);
      chk(lg_idx[0] == 6'd17 && lg_arg[0] == a, "R8", "read command arg", lg_arg[0], a);
      chk(nrcv == 512, "R10", "bytes with valid", nrcv, 512);
      chk(bad_data == 0, "R10", "data mismatches", bad_data, 0);
      chk(nlast == 1 && last_idx == 511, "R10", "rd_last position", last_idx, 511);
      chk(post_bytes == 1 + 1 + tdly + 1 + 512 + 2, "R10", "bytes clocked after command",
          post_bytes, 517 + tdly);
      chk(spi_cs_n == 1'b1, "R10", "cs released", spi_cs_n, 1);
      chk(last_high == FAST, "R7", "sclk high time after bring-up", last_high, FAST);
   endtask

   task automatic t_init_v1();
      cfg_default(); cfg_v2 = 0;
      run_init();
      chk(err == 1'b0 && card_v2 == 1'b0, "R4", "v1 card: err/card_v2", {err, card_v2}, 0);
   endtask

   task automatic t_cmd0_bad();
      cfg_default(); cfg_r1_0 = 8'h00;
      run_init();
      chk(err == 1'b1 && err_code == 4'd1, "R3", "CMD0 R1 not 0x01", err_code, 1);
      chk(ncmd == 1, "R3", "stopped after CMD0", ncmd, 1);
   endtask

   task automatic t_r1_window();
      cfg_default(); cfg_gap = 7;
      run_init();
      chk(err == 1'b0, "R3", "R1 at poll 8 accepted", err_code, 0);
      cfg_default(); cfg_gap = 8;
      run_init();
      chk(err == 1'b1 && err_code == 4'd1, "R3", "R1 beyond 8 polls", err_code, 1);
      chk(spi_cs_n == 1'b1 && busy == 1'b0, "R11", "idle after error", {spi_cs_n, busy}, 2);
   endtask

   task automatic t_acmd_timeout();
      cfg_default(); cfg_busy = 100;
      run_init();
      chk(err == 1'b1 && err_code == 4'd3, "R5", "card stays idle", err_code, 3);
      chk(n_acmd == ACMD, "R5", "ACMD41 tries", n_acmd, ACMD);
   endtask

   task automatic t_cmd16_bad();
      cfg_default(); cfg_r1_16 = 8'h04;
      run_init();
      chk(err == 1'b1 && err_code == 4'd4, "R6", "CMD16 rejected", err_code, 4);
   endtask

   task automatic t_read_r1_bad();
      cfg_default(); cfg_r1_17 = 8'h05;
      run_read(32'h10);
      chk(err == 1'b1 && err_code == 4'd5, "R8", "CMD17 rejected", err_code, 5);
      chk(nrcv == 0 && spi_cs_n == 1'b1, "R8", "no data, cs high", nrcv, 0);
   endtask

   task automatic t_token_cases();
      cfg_default(); cfg_tok = 8'hFC;
      run_read(32'h20);
      chk(err == 1'b1 && err_code == 4'd6, "R9", "wrong token", err_code, 6);
      chk(nrcv == 0, "R9", "no data after wrong token", nrcv, 0);
      t_read_ok(32'h0000_0777, 999);
      cfg_default(); cfg_tokdelay = 1000;
      run_read(32'h30);
      chk(err == 1'b1 && err_code == 4'd7, "R9", "token timeout", err_code, 7);
      chk(nrcv == 0, "R9", "no data after timeout", nrcv, 0);
   endtask

   bit finished = 0;
   initial begin
      cfg_default();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_init_v2();
      t_read_ok(32'h00AB_CDEF, 3);
      t_cmd0_bad();
      t_r1_window();
      t_acmd_timeout();
      t_cmd16_bad();
      t_init_v1();
      t_read_r1_bad();
      t_token_cases();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule